// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port synchronous memory with an 18-bit word split into two 9-bit byte lanes. Every control, the address and the write data are sampled on the rising clock edge. An access starts when one of two address strobes loads a new address and a new chip-select state. The cycles that follow continue a burst. A 2-bit counter replaces the two lowest address bits and steps in linear or interleaved order whenever the advance input is low.

Reads pass through three register stages: the access register, the array read register and the output register. The first word of a burst therefore reaches the bus three clocks after its strobe, and each later beat arrives one clock after the one before it. Writes can update either byte lane or both. A global write overrides the per-lane selects and writes every lane. Output enable is combinational and gates the bus driver at once. The device responds only when all three chip enables were at their active levels at the strobe that started the burst.

Top module: `sync_burst_sram`

## Requirements
- R1: During reset and after it, until a selecting strobe, dq_oe_o is 0.
- R2: A low adsc_ni always loads addr_i and the chip-select state. A low adsp_ni loads them only when ce1_ni is low. Otherwise adsp_ni has no effect, and a running burst continues.
- R3: When adsp_ni and adsc_ni are both low on the same clock, the processor strobe wins. The cycle is a read and the write controls are ignored.
- R4: With mode_i=0 the low two address bits are (start + beat) mod 4, and the upper bits stay fixed. The beat counter increments only on clocks where adv_ni is low and no strobe loads.
- R5: With mode_i=1 the low two address bits are start XOR beat.
- R6: When bwe_ni is low, lane i is written only if bw_ni[i] is low. Lane 0 is dq bits [8:0] and lane 1 is bits [17:9]. With gw_ni and bwe_ni both high, a cycle is a read.
- R7: When gw_ni is low, both lanes are written whatever bwe_ni and bw_ni are.
- R8: The device is selected only if ce1_ni=0, ce2_i=1 and ce3_ni=0 at the loading strobe. A deselected device never writes and never drives the bus.
- R9: A read access sampled at edge k shows its data after edge k+2. Successive beats follow on successive clocks (3-1-1-1).
- R10: dq_oe_o is 1 only while a registered read is valid and oe_ni is low. oe_ni takes effect without waiting for a clock edge.
- R11: A write sampled at edge k is returned by a read of the same address sampled at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Expansion chip enable, active high |
| ce3_ni | input | 1 | Expansion chip enable, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | LANES | Per-lane write selects, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | LANES*LANE_W | Write data from the shared bus |
| dq_o | output | LANES*LANE_W | Read data to the shared bus |
| dq_oe_o | output | 1 | Bus driver enable; 0 means high impedance |

## Verification
The ports can show three kinds of internal fault. A wrong burst counter or wrong order logic returns the word of a neighbouring address two clocks after the bad beat. A bad lane mask or strobe-priority decision corrupts the array silently, and it only becomes visible when that address is read back, three clocks after the read strobe. A lost or extra pipeline stage shifts every read by one cycle, so the first data-phase compare fails. Chip-select faults appear as a driven bus where the bus should float, or as data written while the device was deselected.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burst_mode_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] beat,
                                              input burst_mode_e mode);
    logic [1:0] sum;
    sum = start + beat;
    return (mode == BURST_INTERLEAVE) ? (start ^ beat) : sum;
  endfunction

endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     adsp_ni,
  input  logic                     adsc_ni,
  input  logic                     adv_ni,
  input  logic                     ce1_ni,
  input  logic                     ce2_i,
  input  logic                     ce3_ni,
  input  logic                     mode_i,
  input  logic                     gw_ni,
  input  logic                     bwe_ni,
  input  logic [LANES-1:0]         bw_ni,
  input  logic [LANES*LANE_W-1:0]  din_i,
  output logic                     acc_rd_o,
  output logic                     acc_wr_o,
  output logic [ADDR_W-1:0]        acc_addr_o,
  output logic [LANES-1:0]         acc_mask_o,
  output logic [LANES*LANE_W-1:0]  acc_data_o,
  output logic [1:0]               cnt_o,
  output logic                     sel_o
);
  import sbs_pkg::*;

  localparam int HI_W   = ADDR_W - 2;
  localparam int DATA_W = LANES * LANE_W;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            sel_q, sel_d;

  logic            p_load, c_load, load, sel_now;
  logic [LANES-1:0] mask_d;
  logic            wr_d, rd_d;
  logic [ADDR_W-1:0] addr_d;

  assign p_load  = ~adsp_ni & ~ce1_ni;  // processor strobe needs primary enable
  assign c_load  = ~adsc_ni;
  assign load    = p_load | c_load;
  assign sel_now = ~ce1_ni & ce2_i & ~ce3_ni;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (load) begin
      hi_d   = addr_i[ADDR_W-1:2];
      base_d = addr_i[1:0];
      cnt_d  = 2'd0;
      sel_d  = sel_now;
    end else if (!adv_ni) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  assign addr_d = {hi_d, burst_offset(base_d, cnt_d, burst_mode_e'(mode_i))};

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign mask_d[g] = ~gw_ni | (~bwe_ni & ~bw_ni[g]);
  end

  // processor-strobe cycles are always reads
  assign wr_d = sel_d & ~p_load & (|mask_d);
  assign rd_d = sel_d & ~wr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      sel_q      <= 1'b0;
      acc_rd_o   <= 1'b0;
      acc_wr_o   <= 1'b0;
      acc_addr_o <= '0;
      acc_mask_o <= '0;
      acc_data_o <= '0;
    end else begin
      hi_q       <= hi_d;
      base_q     <= base_d;
      cnt_q      <= cnt_d;
      sel_q      <= sel_d;
      acc_rd_o   <= rd_d;
      acc_wr_o   <= wr_d;
      acc_addr_o <= addr_d;
      acc_mask_o <= mask_d;
      acc_data_o <= din_i[DATA_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_rd_i,
  input  logic                     acc_wr_i,
  input  logic [ADDR_W-1:0]        acc_addr_i,
  input  logic [LANES-1:0]         acc_mask_i,
  input  logic [LANES*LANE_W-1:0]  acc_data_i,
  output logic                     rd_vld_o,
  output logic [LANES*LANE_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (acc_wr_i && acc_mask_i[g]) mem[acc_addr_i] <= acc_data_i[g*LANE_W +: LANE_W];
      if (acc_rd_i) rd_q <= mem[acc_addr_i];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_o <= 1'b0;
    else         rd_vld_o <= acc_rd_i;
  end

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              oe_ni,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      q_q       <= '0;
    end else begin
      out_vld_o <= rd_vld_i;
      if (rd_vld_i) q_q <= rd_data_i;
    end
  end

  assign dq_o    = q_q;
  assign dq_oe_o = out_vld_o & ~oe_ni;  // asynchronous enable

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     adsp_ni,
  input  logic                     adsc_ni,
  input  logic                     adv_ni,
  input  logic                     ce1_ni,
  input  logic                     ce2_i,
  input  logic                     ce3_ni,
  input  logic                     mode_i,
  input  logic                     gw_ni,
  input  logic                     bwe_ni,
  input  logic [LANES-1:0]         bw_ni,
  input  logic                     oe_ni,
  input  logic [LANES*LANE_W-1:0]  dq_i,
  output logic [LANES*LANE_W-1:0]  dq_o,
  output logic                     dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              acc_rd, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_mask;
  logic [DATA_W-1:0] acc_data;
  logic [1:0]        cnt;
  logic              sel;
  logic              rd_vld;
  logic [DATA_W-1:0] rd_data;
  logic              out_vld;

  sbs_addr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .adsp_ni    (adsp_ni),
    .adsc_ni    (adsc_ni),
    .adv_ni     (adv_ni),
    .ce1_ni     (ce1_ni),
    .ce2_i      (ce2_i),
    .ce3_ni     (ce3_ni),
    .mode_i     (mode_i),
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .bw_ni      (bw_ni),
    .din_i      (dq_i),
    .acc_rd_o   (acc_rd),
    .acc_wr_o   (acc_wr),
    .acc_addr_o (acc_addr),
    .acc_mask_o (acc_mask),
    .acc_data_o (acc_data),
    .cnt_o      (cnt),
    .sel_o      (sel)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_rd_i   (acc_rd),
    .acc_wr_i   (acc_wr),
    .acc_addr_i (acc_addr),
    .acc_mask_i (acc_mask),
    .acc_data_i (acc_data),
    .rd_vld_o   (rd_vld),
    .rd_data_o  (rd_data)
  );

  sbs_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_vld_i  (rd_vld),
    .rd_data_i (rd_data),
    .oe_ni     (oe_ni),
    .out_vld_o (out_vld),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       adsp_ni,
  input logic       adsc_ni,
  input logic       adv_ni,
  input logic       ce1_ni,
  input logic       ce2_i,
  input logic       dq_oe_o,
  input logic       acc_rd,
  input logic       acc_wr,
  input logic       rd_vld,
  input logic       out_vld,
  input logic [1:0] cnt,
  input logic       sel
);

  assert_adsp_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && ce1_ni && adsc_ni && adv_ni) |=> ($stable(cnt) && $stable(sel)));

  assert_proc_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce1_ni && !adsc_ni) |=> !acc_wr);

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsp_ni && adsc_ni && adv_ni) |=> $stable(cnt));

  assert_deselect_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && !ce2_i) |=> (!acc_wr && !acc_rd));

  assert_read_stage1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rd |=> rd_vld);

  assert_read_stage2_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld |=> out_vld);

  assert_drive_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(acc_rd, 2));

endmodule

bind sync_burst_sram sbs_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .adsp_ni (adsp_ni),
  .adsc_ni (adsc_ni),
  .adv_ni  (adv_ni),
  .ce1_ni  (ce1_ni),
  .ce2_i   (ce2_i),
  .dq_oe_o (dq_oe_o),
  .acc_rd  (acc_rd),
  .acc_wr  (acc_wr),
  .rd_vld  (rd_vld),
  .out_vld (out_vld),
  .cnt     (cnt),
  .sel     (sel)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW    = 8;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, mode, gw_n, bwe_n, oe_n;
  logic [LN-1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_o;
  logic dq_oe;

  sync_burst_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n),
    .adv_ni(adv_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .mode_i(mode),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n), .dq_i(din),
    .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_base = '0, m_cnt = '0;
  logic          m_sel = 1'b0;
  logic          s1_v = 1'b0, s2_v = 1'b0, o_v = 1'b0;
  logic [DW-1:0] s1_d = '0, s2_d = '0, o_d = '0;

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 1031 + 77);
  endfunction

  task automatic model_edge();
    logic pld, cld, wr;
    logic [1:0] lo;
    logic [LN-1:0] m;
    logic [AW-1:0] a;
    pld = !adsp_n && !ce1_n;
    cld = !adsc_n;
    if (pld || cld) begin
      m_hi = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 2'd0;
      m_sel = !ce1_n && ce2 && !ce3_n;
    end else if (!adv_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    lo = mode ? (m_base ^ m_cnt) : 2'(m_base + m_cnt);
    a = {m_hi, lo};
    for (int i = 0; i < LN; i++) m[i] = !gw_n || (!bwe_n && !bw_n[i]);
    wr = m_sel && !pld && (m != '0);
    o_v = s2_v; o_d = s2_d;
    s2_v = s1_v; s2_d = s1_d;
    s1_v = m_sel && !wr;
    s1_d = ref_mem[a];
    if (wr) for (int i = 0; i < LN; i++)
      if (m[i]) ref_mem[a][i*LW +: LW] = din[i*LW +: LW];
  endtask

  task automatic chk_bus(string tag);
    n_chk++;
    if (o_v && !oe_n) begin
      if (dq_oe !== 1'b1 || dq_o !== o_d) begin
        n_err++;
        $display("FAIL %s bus: oe=%b data=%h expected oe=1 data=%h", tag, dq_oe, dq_o, o_d);
      end
    end else if (dq_oe !== 1'b0) begin
      n_err++;
      $display("FAIL %s bus: oe=%b expected oe=0", tag, dq_oe);
    end
  endtask

  task automatic expect_word(string tag, logic [DW-1:0] exp);
    n_chk++;
    if (dq_oe !== 1'b1 || dq_o !== exp) begin
      n_err++;
      $display("FAIL %s word: oe=%b data=%h expected oe=1 data=%h", tag, dq_oe, dq_o, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk_bus(tag);
  endtask

  task automatic set_idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
  endtask

  task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d, logic g, logic be,
                            logic [LN-1:0] bw, string tag);
    set_idle();
    adsc_n = 1'b0; addr = a; din = d; gw_n = g; bwe_n = be; bw_n = bw;
    cyc(tag);
    set_idle();
  endtask

  task automatic read_word(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    set_idle();
    adsc_n = 1'b0; addr = a;
    cyc(tag);
    set_idle();
    cyc(tag);
    cyc(tag);
    expect_word(tag, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'd20240611));
    set_idle();
    addr = '0; din = '0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; mode = 1'b0; oe_n = 1'b0;

    // R1: bus quiet in and after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_chk++;
      if (dq_oe !== 1'b0) begin
        n_err++;
        $display("FAIL R1 reset: oe=%b expected 0", dq_oe);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R1");

    // fill array with linear global-write bursts
    for (int b = 0; b < DEPTH; b += 4) begin
      set_idle();
      adsc_n = 1'b0; addr = AW'(b); gw_n = 1'b0; din = pat(b);
      cyc("R7");
      for (int k = 1; k < 4; k++) begin
        adsc_n = 1'b1; adv_n = 1'b0; gw_n = 1'b0; din = pat(b + k);
        cyc("R7");
      end
    end
    set_idle();
    cyc("R7");

    // R4/R9: linear burst from offset 2
    adsc_n = 1'b0; addr = 8'h12; cyc("R9");
    set_idle(); adv_n = 1'b0; cyc("R4");
    cyc("R4"); expect_word("R9", pat(8'h12));
    cyc("R4"); expect_word("R4", pat(8'h13));
    set_idle(); cyc("R4"); expect_word("R4", pat(8'h10));
    cyc("R4"); expect_word("R4", pat(8'h11));

    // R5: interleaved burst from offset 3 with one held beat
    mode = 1'b1;
    adsc_n = 1'b0; addr = 8'h23; cyc("R5");
    set_idle(); adv_n = 1'b0; cyc("R5");
    adv_n = 1'b1; cyc("R5"); expect_word("R5", pat(8'h23));
    adv_n = 1'b0; cyc("R5"); expect_word("R5", pat(8'h22));
    cyc("R4"); expect_word("R4", pat(8'h22));
    set_idle(); cyc("R5"); expect_word("R5", pat(8'h21));
    cyc("R5"); expect_word("R5", pat(8'h20));
    mode = 1'b0;

    // R6: lane writes
    w = pat(8'h40);
    write_word(8'h40, 18'h2A5A5, 1'b1, 1'b0, 2'b10, "R6");
    w = {w[17:9], 9'h1A5};
    read_word(8'h40, w, "R6");
    write_word(8'h40, 18'h15C3C, 1'b1, 1'b0, 2'b01, "R6");
    w = {9'h0AE, w[8:0]};
    read_word(8'h40, w, "R6");
    write_word(8'h40, 18'h3FFFF, 1'b1, 1'b1, 2'b00, "R6");
    read_word(8'h40, w, "R6");

    // R7: global write overrides lane selects
    write_word(8'h41, 18'h0BEEF, 1'b0, 1'b1, 2'b11, "R7");
    read_word(8'h41, 18'h0BEEF, "R7");

    // R3: both strobes -> read, write ignored
    set_idle();
    adsp_n = 1'b0; adsc_n = 1'b0; addr = 8'h42; gw_n = 1'b0; din = 18'h00001;
    cyc("R3");
    set_idle(); cyc("R3"); cyc("R3"); expect_word("R3", pat(8'h42));
    read_word(8'h42, pat(8'h42), "R3");

    // R2: processor strobe loads with ce1 low, ignored with ce1 high
    adsp_n = 1'b0; addr = 8'h50; cyc("R2");
    set_idle(); cyc("R2"); cyc("R2"); expect_word("R2", pat(8'h50));
    adsc_n = 1'b0; addr = 8'h60; cyc("R2");
    set_idle(); adsp_n = 1'b0; ce1_n = 1'b1; addr = 8'h70; adv_n = 1'b0; cyc("R2");
    set_idle(); ce1_n = 1'b0; cyc("R2"); expect_word("R2", pat(8'h60));
    cyc("R2"); expect_word("R2", pat(8'h61));

    // R8: deselect by ce2, then attempted write with ce3 inactive
    adsc_n = 1'b0; ce2 = 1'b0; addr = 8'h44; cyc("R8");
    set_idle(); ce2 = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R8");
    adsc_n = 1'b0; ce3_n = 1'b1; addr = 8'h45; gw_n = 1'b0; din = 18'h12345; cyc("R8");
    adsc_n = 1'b1; adv_n = 1'b0; cyc("R8");
    set_idle(); ce3_n = 1'b0; cyc("R8");
    read_word(8'h45, pat(8'h45), "R8");

    // R11: write then read on the next clock
    write_word(8'h55, 18'h2C0DE, 1'b0, 1'b1, 2'b11, "R11");
    adsc_n = 1'b0; addr = 8'h55; cyc("R11");
    set_idle(); cyc("R11"); cyc("R11"); expect_word("R11", 18'h2C0DE);

    // R10: asynchronous output enable
    read_word(8'h30, pat(8'h30), "R10");
    oe_n = 1'b1; #1;
    n_chk++;
    if (dq_oe !== 1'b0) begin
      n_err++;
      $display("FAIL R10 oe high: oe=%b expected 0", dq_oe);
    end
    oe_n = 1'b0; #1;
    expect_word("R10", pat(8'h30));
    cyc("R10");

    // constrained random traffic
    for (int i = 0; i < 1500; i++) begin
      int s;
      s = int'($urandom % 8);
      adsp_n = !(s == 0 || s == 2);
      adsc_n = !(s == 1 || s == 2);
      addr   = AW'($urandom);
      adv_n  = 1'($urandom % 2);
      ce1_n  = ($urandom % 8) == 0;
      ce2    = ($urandom % 10) != 0;
      ce3_n  = ($urandom % 10) == 0;
      gw_n   = ($urandom % 4) != 0;
      bwe_n  = 1'($urandom % 2);
      bw_n   = LN'($urandom);
      din    = DW'($urandom);
      mode   = 1'($urandom % 2);
      oe_n   = ($urandom % 5) == 0;
      cyc("R9");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule